// File: doc/BRIEF.md
# Programmable Test Pattern Generator

This block emits a serial test stream, one bit for every clock edge on which the transmit clock enable is high. The stream comes from a 32-bit shift register in one of two modes. In pseudorandom mode the register is fed back through two runtime taps. In repetitive mode the register rotates a user word of 1 to 32 bits. Software writes a seed or pattern word, a length index, a tap index and a mode bit. A rising edge on the load control then starts the new pattern.

Three stages process the raw pattern bit, in this order. A zero-run guard can force a one so that long zero runs are broken up, which suits quasi-random patterns. An error injector inverts single bits, either at a fixed decade interval or once per strobe. A final stage can invert the whole stream. The result is registered and drives `dout`, and `dout_vld` marks that a loaded pattern is being emitted. Link test equipment uses the block to stress a channel with a known stream and a known error rate.

Top module: `ptg_top`

## Requirements
- R1: After reset, `dout` and `dout_vld` are both 0. They stay 0 through enabled clocks until a pattern has been loaded.
- R2: A rising edge of (`load_reg` OR `load_pin`) copies `seed` into the shift register, clears `dout_vld` and restarts the error interval count. The first enabled edge after that emits the first bit and sets `dout_vld`. Holding the load control high causes no further reload.
- R3: With `prbs_mode`=1, each emitted pattern bit is register bit [`len_sel`]. The feedback bit, register bit [`len_sel`] XOR register bit [`tap_sel`], shifts into bit 0 as the register moves toward its MSB. With an all-ones seed, `len_sel`=6 and `tap_sel`=5, the stream has period 127.
- R4: With `prbs_mode`=0, the low `len_sel`+1 bits of the seed repeat circularly, starting at bit [`len_sel`] and descending to bit 0. `len_sel`=0 repeats seed bit 0. `len_sel`=31 repeats the whole word.
- R5: On a clock edge with `clk_en`=0 and no load edge, `dout`, `dout_vld` and the pattern position are all unchanged.
- R6: With `zsup_en`=1, a pattern bit that would be the 15th zero in a row is emitted as a one. The shift register sequence itself is unaffected.
- R7: With `tx_inv`=1, every emitted bit is the complement of what would be emitted with `tx_inv`=0.
- R8: A rising edge of `err_single` inverts exactly the next emitted bit. Keeping `err_single` high inserts no further error. A new error needs the strobe to return low and rise again.
- R9: `err_rate` code c in 1..7 inverts emitted bit numbers k·10^c (counting from 1 after the last load). Code 0 inserts no periodic errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Enables one bit of output on this edge |
| seed | input | 32 | Seed (all ones for pseudorandom) or pattern word |
| len_sel | input | 5 | Pattern length minus one; first feedback tap |
| tap_sel | input | 5 | Second feedback tap position |
| prbs_mode | input | 1 | 1 = pseudorandom, 0 = repetitive |
| load_reg | input | 1 | Load control, register bit |
| load_pin | input | 1 | Load control, pin; ORed with load_reg |
| zsup_en | input | 1 | Force a one after 14 zeros |
| tx_inv | input | 1 | Invert the output stream |
| err_rate | input | 3 | Periodic error interval code |
| err_single | input | 1 | Single error strobe, acts on rising edge |
| dout | output | 1 | Serial test bit |
| dout_vld | output | 1 | A loaded pattern is being emitted |

## Verification
The bench targets the extreme pattern lengths (1 and 32 bits), where an off-by-one in the tap index would shift or truncate the word. It runs an all-zero word with zero suppression, where forcing on the 14th zero instead of the 15th shortens every period. It checks that a strobe held high gives only one error, since a level-sensitive design would corrupt every bit. It checks that gapped clocking freezes the stream, since a design that shifts on every edge would skip bits. Decade error spacing is checked over several intervals, which catches an injector that counts from zero or fires one bit early.

// File: rtl/ptg_pkg.sv
// Package: shared constants and the decade interval lookup for the
// programmable test pattern generator. Assumes codes beyond 7 never occur
// (the field is 3 bits wide).
package ptg_pkg;

    localparam int SEED_W       = 32;
    localparam int LEN_W        = $clog2(SEED_W);
    localparam int RATE_W       = 3;
    localparam int ZERO_RUN_MAX = 14;
    localparam int ERR_CNT_W    = 24;

    // Number of bits between periodic errors for a rate code (0 = none).
    function automatic logic [ERR_CNT_W-1:0] decade_span(input logic [RATE_W-1:0] code);
        logic [ERR_CNT_W-1:0] span;
        case (code)
            3'd1:    span = ERR_CNT_W'(10);
            3'd2:    span = ERR_CNT_W'(100);
            3'd3:    span = ERR_CNT_W'(1000);
            3'd4:    span = ERR_CNT_W'(10000);
            3'd5:    span = ERR_CNT_W'(100000);
            3'd6:    span = ERR_CNT_W'(1000000);
            3'd7:    span = ERR_CNT_W'(10000000);
            default: span = ERR_CNT_W'(1);
        endcase
        return span;
    endfunction

endpackage

// File: rtl/ptg_shift_core.sv
// Shift core: one register serves both modes. The emitted bit is always
// sr[len_idx]. In pseudorandom mode sr[len_idx]^sr[tap_idx] shifts in at
// bit 0; in repetitive mode sr[len_idx] itself shifts in, which rotates
// the low len_idx+1 bits. Bits above len_idx are don't-care.
// Assumes load and step are never both high (top gives load priority).
module ptg_shift_core #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          prbs_mode,
    input  logic [W-1:0]  seed,
    input  logic [IW-1:0] len_idx,
    input  logic [IW-1:0] tap_idx,
    output logic          pat_bit
);

    logic [W-1:0] sr;
    logic         fb;

    // Select the current pattern bit and the bit fed back into position 0.
    always_comb begin
        pat_bit = sr[len_idx];
        fb      = prbs_mode ? (sr[len_idx] ^ sr[tap_idx]) : sr[len_idx];
    end

    // Load the seed, or advance one position per enabled step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= seed;
        end else if (step) begin
            sr <= {sr[W-2:0], fb};
        end
    end

endmodule

// File: rtl/ptg_zero_guard.sv
// Zero-run guard: counts consecutive zeros in the stream it emits and,
// when enabled, turns the bit that would extend a run past MAX_RUN into a
// one. Only the output is altered, never the shift core state.
module ptg_zero_guard #(
    parameter int MAX_RUN = 14,
    parameter int RW      = $clog2(MAX_RUN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic guard_en,
    input  logic raw_bit,
    output logic guarded_bit
);

    logic [RW-1:0] run;
    logic          at_limit;

    // Decide whether this bit must be forced high.
    always_comb begin
        at_limit    = (run >= RW'(MAX_RUN));
        guarded_bit = raw_bit | (guard_en & at_limit);
    end

    // Track the zero run of emitted bits, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run <= '0;
        end else if (step) begin
            if (guarded_bit)   run <= '0;
            else if (!at_limit) run <= run + 1'b1;
        end
    end

endmodule

// File: rtl/ptg_error_inject.sv
// Error injector: a decade interval counter flags every span-th emitted
// bit, and a single-error strobe arms one pending flip on its rising edge.
// The strobe edge is seen on every clock; the flip is spent on the next
// step. Assumes rate changes only while a pattern is being (re)loaded.
module ptg_error_inject #(
    parameter int CW = ptg_pkg::ERR_CNT_W,
    parameter int RW = ptg_pkg::RATE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [RW-1:0] rate,
    input  logic          single,
    output logic          flip,
    output logic          pend
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_pos;
    logic          single_q;
    logic          single_rise;
    logic          periodic_hit;

    // Find the last position of the interval and whether this bit hits it.
    always_comb begin
        last_pos     = ptg_pkg::decade_span(rate) - 1'b1;
        periodic_hit = (rate != '0) && (cnt >= last_pos);
        single_rise  = single & ~single_q;
        flip         = periodic_hit | pend;
    end

    // Count emitted bits within the current interval.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || rate == '0) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= periodic_hit ? '0 : cnt + 1'b1;
        end
    end

    // Edge-detect the strobe and hold one pending flip until it is used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single_q <= 1'b0;
            pend     <= 1'b0;
        end else begin
            single_q <= single;
            if (single_rise)  pend <= 1'b1;
            else if (step)    pend <= 1'b0;
        end
    end

endmodule

// File: rtl/ptg_top.sv
// Programmable test pattern generator, top level. Detects the load edge,
// gates generation with clk_en, chains shift core -> zero guard -> error
// injector -> inversion and registers the result onto dout.
// Assumes all control inputs are synchronous to clk.
module ptg_top #(
    parameter int SEED_W  = ptg_pkg::SEED_W,
    parameter int LEN_W   = ptg_pkg::LEN_W,
    parameter int RATE_W  = ptg_pkg::RATE_W,
    parameter int MAX_RUN = ptg_pkg::ZERO_RUN_MAX,
    parameter int CNT_W   = ptg_pkg::ERR_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [SEED_W-1:0] seed,
    input  logic [LEN_W-1:0]  len_sel,
    input  logic [LEN_W-1:0]  tap_sel,
    input  logic              prbs_mode,
    input  logic              load_reg,
    input  logic              load_pin,
    input  logic              zsup_en,
    input  logic              tx_inv,
    input  logic [RATE_W-1:0] err_rate,
    input  logic              err_single,
    output logic              dout,
    output logic              dout_vld
);

    logic load_any;
    logic load_q;
    logic load_rise;
    logic active;
    logic step;
    logic pat_bit;
    logic guarded_bit;
    logic flip;
    logic pend;
    logic dout_q;
    logic vld_q;

    // Combine load sources, find the edge and qualify the step.
    always_comb begin
        load_any  = load_reg | load_pin;
        load_rise = load_any & ~load_q;
        step      = clk_en & active & ~load_rise;
    end

    // Remember the load level and whether a pattern has been loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= 1'b0;
            active <= 1'b0;
        end else begin
            load_q <= load_any;
            if (load_rise) active <= 1'b1;
        end
    end

    ptg_shift_core #(
        .W  (SEED_W),
        .IW (LEN_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_rise),
        .step      (step),
        .prbs_mode (prbs_mode),
        .seed      (seed),
        .len_idx   (len_sel),
        .tap_idx   (tap_sel),
        .pat_bit   (pat_bit)
    );

    ptg_zero_guard #(
        .MAX_RUN (MAX_RUN)
    ) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (load_rise),
        .step        (step),
        .guard_en    (zsup_en),
        .raw_bit     (pat_bit),
        .guarded_bit (guarded_bit)
    );

    ptg_error_inject #(
        .CW (CNT_W),
        .RW (RATE_W)
    ) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (load_rise),
        .step   (step),
        .rate   (err_rate),
        .single (err_single),
        .flip   (flip),
        .pend   (pend)
    );

    // Register the final bit and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
            vld_q  <= 1'b0;
        end else if (load_rise) begin
            vld_q  <= 1'b0;
        end else if (step) begin
            dout_q <= guarded_bit ^ flip ^ tx_inv;
            vld_q  <= 1'b1;
        end
    end

    assign dout     = dout_q;
    assign dout_vld = vld_q;

endmodule

// File: rtl/ptg_checker.sv
// Checker for ptg_top: gating, load, zero-run and strobe properties.
// Keeps its own edge and run trackers so nothing is copied from the RTL.
module ptg_checker #(
    parameter int MAX_RUN = 14
) (
    input logic clk,
    input logic rst_n,
    input logic clk_en,
    input logic load_reg,
    input logic load_pin,
    input logic zsup_en,
    input logic err_single,
    input logic step,
    input logic guarded_bit,
    input logic pend,
    input logic dout,
    input logic dout_vld
);

    logic       ld_q;
    logic       st_q;
    logic [4:0] zrun;
    logic       ld_edge;
    logic       st_edge;

    assign ld_edge = (load_reg | load_pin) & ~ld_q;
    assign st_edge = err_single & ~st_q;

    // Track control levels and the zero run seen after the guard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q <= 1'b0;
            st_q <= 1'b0;
            zrun <= '0;
        end else begin
            ld_q <= load_reg | load_pin;
            st_q <= err_single;
            if (ld_edge)             zrun <= '0;
            else if (step) begin
                if (guarded_bit)     zrun <= '0;
                else if (zrun != 5'd31) zrun <= zrun + 1'b1;
            end
        end
    end

    // R5
    gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !ld_edge) |=> ($stable(dout) && $stable(dout_vld)));

    // R2
    load_clears_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_edge |=> !dout_vld);

    // R2
    step_sets_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> dout_vld);

    // R6
    zero_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && zsup_en && zrun >= 5'(MAX_RUN)) |-> guarded_bit);

    // R8
    single_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_edge |=> pend);

    // R8
    single_spend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !st_edge) |=> !pend);

endmodule

bind ptg_top ptg_checker #(.MAX_RUN(MAX_RUN)) u_ptg_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_en      (clk_en),
    .load_reg    (load_reg),
    .load_pin    (load_pin),
    .zsup_en     (zsup_en),
    .err_single  (err_single),
    .step        (step),
    .guarded_bit (guarded_bit),
    .pend        (pend),
    .dout        (dout),
    .dout_vld    (dout_vld)
);

// File: tb/ptg_top_test.sv
`timescale 1ns/1ps
module ptg_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic [31:0] seed = '0;
    logic [4:0]  len_sel = '0;
    logic [4:0]  tap_sel = '0;
    logic        prbs_mode = 1'b0;
    logic        load_reg = 1'b0;
    logic        load_pin = 1'b0;
    logic        zsup_en = 1'b0;
    logic        tx_inv = 1'b0;
    logic [2:0]  err_rate = '0;
    logic        err_single = 1'b0;
    logic        dout;
    logic        dout_vld;

    int checks = 0;
    int errors = 0;

    // reference state built from the requirements
    logic [31:0] m_sr;
    int          m_len, m_tap, m_run, m_idx, m_span, m_rate;
    logic        m_prbs, m_zs, m_inv, m_single;

    always #4 clk = ~clk;

    ptg_top uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .seed(seed),
        .len_sel(len_sel), .tap_sel(tap_sel), .prbs_mode(prbs_mode),
        .load_reg(load_reg), .load_pin(load_pin), .zsup_en(zsup_en),
        .tx_inv(tx_inv), .err_rate(err_rate), .err_single(err_single),
        .dout(dout), .dout_vld(dout_vld)
    );

    task automatic check(input bit ok, input string tag, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            clk_en = 1'b0;
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic do_load(input logic [31:0] s, input int len, input int tap,
                           input logic prbs, input logic zs, input logic inv, input int rate);
        seed = s; len_sel = 5'(len); tap_sel = 5'(tap); prbs_mode = prbs;
        zsup_en = zs; tx_inv = inv; err_rate = 3'(rate);
        clk_en = 1'b0; load_pin = 1'b1;
        @(posedge clk); @(negedge clk);
        load_pin = 1'b0;
        check(dout_vld == 1'b0, "R2 vld cleared by load", dout_vld, 1'b0);
        m_sr = s; m_len = len; m_tap = tap; m_prbs = prbs; m_zs = zs; m_inv = inv;
        m_rate = rate; m_run = 0; m_idx = 0; m_single = 1'b0;
        m_span = (rate == 0) ? 1 : 10 ** rate;
    endtask

    // one enabled bit, expected value from the reference state
    task automatic run_bits(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            logic pat, nb, e, exp_b;
            pat = m_sr[m_len];
            nb  = m_prbs ? (pat ^ m_sr[m_tap]) : pat;
            m_sr = {m_sr[30:0], nb};
            if (m_zs && !pat && m_run >= 14) pat = 1'b1;
            m_run = pat ? 0 : m_run + 1;
            m_idx++;
            e = m_single; m_single = 1'b0;
            if (m_rate != 0 && (m_idx % m_span) == 0) e = 1'b1;
            exp_b = pat ^ e ^ m_inv;
            clk_en = 1'b1;
            @(posedge clk); @(negedge clk);
            clk_en = 1'b0;
            check(dout === exp_b && dout_vld === 1'b1, tag, dout, exp_b);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(dout == 1'b0, "R1 dout in reset", dout, 1'b0);
        check(dout_vld == 1'b0, "R1 vld in reset", dout_vld, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            clk_en = 1'b1;
            @(posedge clk); @(negedge clk);
            check(dout_vld == 1'b0 && dout == 1'b0, "R1 idle before load", dout_vld, 1'b0);
        end
        clk_en = 1'b0;
    endtask

    task automatic t_prbs();
        do_load(32'hFFFF_FFFF, 6, 5, 1'b1, 1'b0, 1'b0, 0);
        run_bits(254, "R3 prbs len6 tap5");
        do_load(32'hFFFF_FFFF, 8, 4, 1'b1, 1'b0, 1'b0, 0);
        run_bits(100, "R3 prbs len8 tap4");
    endtask

    // explicit word rotation, independent of the reference state
    task automatic rep_word(input logic [31:0] w, input int len, input int n, input logic inv);
        do_load(w, len, 0, 1'b0, 1'b0, inv, 0);
        for (int i = 0; i < n; i++) begin
            logic exp_b;
            exp_b = w[len - (i % (len + 1))] ^ inv;
            clk_en = 1'b1;
            @(posedge clk); @(negedge clk);
            clk_en = 1'b0;
            check(dout === exp_b, inv ? "R7 inverted word" : "R4 repeated word", dout, exp_b);
        end
    endtask

    task automatic t_repeat();
        rep_word(32'h0000_00A5, 7, 24, 1'b0);
        rep_word(32'h0000_0001, 0, 6, 1'b0);
        rep_word(32'hDEAD_BEEF, 31, 64, 1'b0);
    endtask

    task automatic t_inv();
        rep_word(32'h0000_00A5, 7, 16, 1'b1);
        do_load(32'hFFFF_FFFF, 6, 5, 1'b1, 1'b0, 1'b1, 0);
        run_bits(40, "R7 inverted prbs");
    endtask

    task automatic t_gap();
        do_load(32'hFFFF_FFFF, 6, 5, 1'b1, 1'b0, 1'b0, 0);
        for (int k = 0; k < 30; k++) begin
            logic d0;
            run_bits(1, "R5 gapped stream");
            if (k % 3 == 0) begin
                d0 = dout;
                idle(2);
                check(dout === d0 && dout_vld === 1'b1, "R5 hold while disabled", dout, d0);
            end
        end
    endtask

    task automatic t_zsup();
        do_load(32'h0, 31, 0, 1'b0, 1'b1, 1'b0, 0);
        for (int i = 0; i < 45; i++) begin
            logic exp_b;
            exp_b = ((i % 15) == 14);
            clk_en = 1'b1;
            @(posedge clk); @(negedge clk);
            clk_en = 1'b0;
            check(dout === exp_b, "R6 zero run broken", dout, exp_b);
        end
        do_load(32'h8000_0000, 31, 0, 1'b0, 1'b1, 1'b0, 0);
        run_bits(96, "R6 state untouched by guard");
        do_load(32'h0, 31, 0, 1'b0, 1'b0, 1'b0, 0);
        run_bits(20, "R6 no guard when disabled");
    endtask

    task automatic t_single();
        do_load(32'hFFFF_FFFF, 6, 5, 1'b1, 1'b0, 1'b0, 0);
        run_bits(5, "R8 before strobe");
        err_single = 1'b1; idle(1);
        m_single = 1'b1;
        run_bits(1, "R8 one flipped bit");
        run_bits(15, "R8 held strobe adds none");
        err_single = 1'b0; idle(1);
        run_bits(3, "R8 after release");
        err_single = 1'b1; idle(1);
        m_single = 1'b1;
        run_bits(4, "R8 second strobe");
        err_single = 1'b0;
    endtask

    task automatic t_rate();
        do_load(32'hFFFF_FFFF, 6, 5, 1'b1, 1'b0, 1'b0, 1);
        run_bits(35, "R9 every 10th bit");
        do_load(32'h0000_00A5, 7, 0, 1'b0, 1'b0, 1'b0, 2);
        run_bits(210, "R9 every 100th bit");
    endtask

    task automatic t_reload();
        do_load(32'hFFFF_FFFF, 6, 5, 1'b1, 1'b0, 1'b0, 0);
        run_bits(20, "R2 before reload");
        load_reg = 1'b1; clk_en = 1'b1;
        @(posedge clk); @(negedge clk);
        clk_en = 1'b0;
        check(dout_vld == 1'b0, "R2 reload clears vld", dout_vld, 1'b0);
        m_sr = 32'hFFFF_FFFF; m_run = 0; m_idx = 0;
        run_bits(30, "R2 restart, level held");
        load_reg = 1'b0;
        run_bits(5, "R2 after release");
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_up();
    end

    initial begin
        t_reset();
        t_prbs();
        t_repeat();
        t_inv();
        t_gap();
        t_zsup();
        t_single();
        t_rate();
        t_reload();
        finish_up();
    end

endmodule